// File: doc/BRIEF.md
# Shared-Memory Command Ring Reader

This block drains a circular command queue that lives in a memory region shared with a software producer. The region's first four 32-bit words describe the queue: word 0 is the lowest byte offset of the ring storage, word 1 is the byte offset one past its end, word 2 is where the producer will write next, and word 3 is where the consumer will read next. The producer appends words and moves word 2. The reader pulls each word found between its own pointer and the producer's pointer, presents it on a valid/ready stream, and publishes its progress by rewriting word 3.

The ring never fills completely. The producer stops one word short, so equal pointers always mean the ring is empty. A configuration-enable input gates all fetching. When the enable rises, the reader loads the bounds and its own pointer from the header. A sync request raises a busy flag, which drops once the reader has seen both pointers equal.

The memory sits outside the block behind a single synchronous port with a one-cycle read latency. The block does not interpret command contents.

Top module: `ring_consumer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `busy` and `mem_req` are all 0.
- R2: When `cfg_done` is 1 in the idle state, the block reads header word 0 (minimum), word 1 (maximum) and word 3 (consumer offset), and starts fetching at that consumer offset.
- R3: Ring words are delivered in exactly the order the producer wrote them: the word at the consumer offset first, and nothing beyond the producer offset.
- R4: Advancing a byte offset adds 4; if the result equals the maximum, the new offset is the minimum instead.
- R5: While word 2 equals the consumer offset, no word is presented, and the block keeps re-reading word 2 until it differs.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` stays unchanged, no memory access is made, and word 3 is not rewritten.
- R7: After each accepted word, the advanced consumer offset (byte units) is written to word 3 before the next ring word is read.
- R8: While `cfg_done` is 0, no read of ring storage (word address above 3) is issued. Pending data waits until `cfg_done` returns to 1.
- R9: A `sync_req` pulse makes `busy` 1 on the next cycle. `busy` returns to 0 only after the block reads word 2 and finds it equal to the consumer offset.
- R10: The block's memory writes go only to word address 3, and the written offset is 4-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done | input | 1 | Ring configured; fetching allowed while 1 |
| sync_req | input | 1 | One-cycle request to track drain completion |
| busy | output | 1 | Set by sync request, cleared when the ring is seen empty |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable (read when 0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read strobe |
| out_valid | output | 1 | Command word available |
| out_data | output | 32 | Command word |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
The bench uses a small ring of six slots, so the wrap from the maximum back to the minimum happens often. A design that compared against the maximum off by one word would lose or repeat a word at every pass. A full ring of five words is held back with the ready input low. A reader that mistook a full ring for an empty one, or rewrote its pointer while stalled, would show up in the delivered sequence or in word 3. The bench freezes the reader, moves the ring to new bounds and re-enables it, which catches bounds that are not reloaded. Sync pulses are raised while data is still pending, which catches a busy flag that clears before the pointers meet.

// File: rtl/ring_pkg.sv
// Package: shared types and header layout for the command ring reader.
// Assumes: header word order is fixed (min, max, producer, consumer).
package ring_pkg;
    localparam int HDR_MIN  = 0;
    localparam int HDR_MAX  = 1;
    localparam int HDR_PROD = 2;
    localparam int HDR_CONS = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LMIN,
        ST_LMAX,
        ST_LCONS,
        ST_POLL,
        ST_PCAP,
        ST_FETCH,
        ST_FCAP,
        ST_HOLD,
        ST_WB
    } ring_state_e;
endpackage

// File: rtl/ring_wrap_adv.sv
// Module: advances a byte offset by one word, wrapping at the upper bound.
// Assumes: offsets are word aligned and lo < hi.
module ring_wrap_adv #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur_off,
    input  logic [DW-1:0] lo_off,
    input  logic [DW-1:0] hi_off,
    output logic [DW-1:0] nxt_off
);
    localparam int STEP = DW / 8;

    logic [DW-1:0] inc_off;

    // Increment, then replace with the lower bound on reaching the upper bound.
    always_comb begin
        inc_off = cur_off + DW'(STEP);
        nxt_off = (inc_off == hi_off) ? lo_off : inc_off;
    end
endmodule

// File: rtl/ring_sync_tracker.sv
// Module: busy flag raised by a sync request, dropped when the ring is seen empty.
// Assumes: empty_seen is a single-cycle observation from a fresh producer read.
module ring_sync_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic empty_seen,
    output logic busy
);
    // Set has priority over clear so that a request is never lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (sync_req)
            busy <= 1'b1;
        else if (empty_seen)
            busy <= 1'b0;
    end
endmodule

// File: rtl/ring_mem_mux.sv
// Module: turns the reader state into one memory access per cycle.
// Assumes: memory returns read data one cycle after the strobe.
module ring_mem_mux
    import ring_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  ring_state_e   state,
    input  logic          cfg_done,
    input  logic [AW-1:0] ring_waddr,
    input  logic [DW-1:0] cons_off,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    // Select address and direction from the state; idle states leave the port quiet.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = cons_off;
        unique case (state)
            ST_IDLE:  if (cfg_done) begin mem_req = 1'b1; mem_addr = AW'(HDR_MIN); end
            ST_LMIN:  begin mem_req = 1'b1; mem_addr = AW'(HDR_MAX); end
            ST_LMAX:  begin mem_req = 1'b1; mem_addr = AW'(HDR_CONS); end
            ST_POLL:  if (cfg_done) begin mem_req = 1'b1; mem_addr = AW'(HDR_PROD); end
            ST_FETCH: if (cfg_done) begin mem_req = 1'b1; mem_addr = ring_waddr; end
            ST_WB:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = AW'(HDR_CONS); end
            default:  ;
        endcase
    end
endmodule

// File: rtl/ring_consumer.sv
// Module: top of the command ring reader. Loads the ring header, follows the
// producer offset, streams ring words out and publishes its own offset.
// Assumes: single synchronous memory port, one-cycle read latency, header in
// words 0..3, ring storage above the header.
module ring_consumer
    import ring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_done,
    input  logic          sync_req,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [31:0]   out_data,
    input  logic          out_ready
);
    localparam int DW    = 32;
    localparam int SHIFT = $clog2(DW / 8);

    ring_state_e   state;
    logic [DW-1:0] lo_off, hi_off, cons_off, prod_off, cons_adv;
    logic [DW-1:0] data_q;
    logic          empty_seen;
    logic [AW-1:0] ring_waddr;

    assign ring_waddr = cons_off[AW+SHIFT-1:SHIFT];
    assign empty_seen = (state == ST_PCAP) && (mem_rdata == cons_off);
    assign out_valid  = (state == ST_HOLD);
    assign out_data   = data_q;

    ring_wrap_adv #(.DW(DW)) u_adv (
        .cur_off (cons_off),
        .lo_off  (lo_off),
        .hi_off  (hi_off),
        .nxt_off (cons_adv)
    );

    ring_sync_tracker u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req   (sync_req),
        .empty_seen (empty_seen),
        .busy       (busy)
    );

    ring_mem_mux #(.AW(AW), .DW(DW)) u_mux (
        .state      (state),
        .cfg_done   (cfg_done),
        .ring_waddr (ring_waddr),
        .cons_off   (cons_off),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    // Sequencer: header load, producer polling, fetch, hand-off and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lo_off   <= '0;
            hi_off   <= '0;
            cons_off <= '0;
            prod_off <= '0;
            data_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE:  if (cfg_done) state <= ST_LMIN;
                ST_LMIN:  begin lo_off <= mem_rdata; state <= ST_LMAX; end
                ST_LMAX:  begin hi_off <= mem_rdata; state <= ST_LCONS; end
                ST_LCONS: begin cons_off <= mem_rdata; state <= ST_POLL; end
                ST_POLL:  state <= cfg_done ? ST_PCAP : ST_IDLE;
                ST_PCAP: begin
                    prod_off <= mem_rdata;
                    state    <= (mem_rdata == cons_off) ? ST_POLL : ST_FETCH;
                end
                ST_FETCH: state <= cfg_done ? ST_FCAP : ST_IDLE;
                ST_FCAP:  begin data_q <= mem_rdata; state <= ST_HOLD; end
                ST_HOLD: if (out_ready) begin
                    cons_off <= cons_adv;
                    state    <= ST_WB;
                end
                ST_WB:    state <= (cons_off == prod_off) ? ST_POLL : ST_FETCH;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_consumer_chk.sv
// Module: property checker for the ring reader, attached by bind.
// Assumes: observes top-level ports only.
module ring_consumer_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_done,
    input logic          sync_req,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          out_valid,
    input logic [31:0]   out_data,
    input logic          out_ready
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

    // R7
    accept_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> mem_req && mem_we);

    // R8
    frozen_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done && mem_req && !mem_we |-> mem_addr <= AW'(3));

    // R9
    sync_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> busy);

    // R10
    wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr == AW'(3) && mem_wdata[1:0] == 2'b00);
endmodule

bind ring_consumer ring_consumer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .sync_req  (sync_req),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/ring_consumer_test.sv
module ring_consumer_test;
    localparam int AW = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, cfg_done, sync_req, busy;
    logic          mem_req, mem_we, out_valid, out_ready;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata, out_data;

    ring_consumer #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .sync_req(sync_req),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready)
    );

    logic [31:0] mem [0:(1<<AW)-1];
    logic [31:0] expq [0:255];
    int head, tail, checks, fails;
    int rd_prod_cnt, rd_ring_cnt;
    int rmode;
    int cur_min, cur_max;
    bit stall_prev;
    logic [31:0] prev_data, prev_cons;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected wrap rule, from R4.
    function automatic int adv(input int off);
        return (off + 4 == cur_max) ? cur_min : off + 4;
    endfunction

    // Synchronous memory model, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr];
                if (mem_addr == 2) rd_prod_cnt++;
                if (mem_addr > 3) rd_ring_cnt++;
            end
        end
    end

    // Downstream side: drives ready and checks delivered words.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev && out_valid) begin
                chk(out_data == prev_data, "R6 data held", out_data, prev_data);
                chk(mem[3] == prev_cons, "R6 no write-back", mem[3], prev_cons);
            end
            case (rmode)
                0: out_ready = ($urandom % 3) != 0;
                1: out_ready = 1'b1;
                default: out_ready = 1'b0;
            endcase
            if (out_valid && out_ready) begin
                if (head == tail) chk(1'b0, "R5 word while empty", out_data, 0);
                else begin
                    chk(out_data == expq[head % 256], "R3 order", out_data, expq[head % 256]);
                    head++;
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_data  = out_data;
            prev_cons  = mem[3];
        end
    end

    task automatic setup_ring(input int lo, input int hi, input int start);
        mem[0] = lo; mem[1] = hi; mem[2] = start; mem[3] = start;
        cur_min = lo; cur_max = hi;
    endtask

    task automatic push(input logic [31:0] val);
        int nxt;
        nxt = adv(int'(mem[2]));
        while (nxt == int'(mem[3])) @(negedge clk);
        mem[mem[2] >> 2] = val;
        mem[2] = nxt;
        expq[tail % 256] = val;
        tail++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sync(input string tag);
        int lim;
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk(busy == 1'b1, tag, busy, 1);
        lim = 0;
        while (busy && lim < 2000) begin @(negedge clk); lim++; end
        chk(busy == 1'b0 && head == tail, tag, tail - head, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int snap;
        process::self().srandom(32'h5eed);
        for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
        rst_n = 0; cfg_done = 0; sync_req = 0; out_ready = 0; rmode = 1;
        head = 0; tail = 0; checks = 0; fails = 0;
        setup_ring(16, 40, 16);
        idle(5);
        // R1 reset state
        chk(!out_valid && !busy && !mem_req, "R1 reset", {out_valid, busy, mem_req}, 0);
        rst_n = 1;
        idle(3);
        chk(!mem_req, "R1 idle after reset", mem_req, 0);

        cfg_done = 1;
        idle(20);
        // R5 empty ring: polling only
        chk(!out_valid && rd_prod_cnt > 2 && rd_ring_cnt == 0, "R5 empty poll", rd_prod_cnt, 3);

        // R3 and R7 directed
        for (int i = 0; i < 3; i++) push(32'hA000 + i);
        idle(30);
        chk(head == tail, "R3 drained", head, tail);
        chk(mem[3] == 28, "R7 write-back", mem[3], 28);

        // R4 wrap at max
        for (int i = 0; i < 3; i++) push(32'hB000 + i);
        idle(30);
        chk(mem[3] == 16, "R4 wrap to min", mem[3], 16);

        // R6 full ring under backpressure
        rmode = 2;
        for (int i = 0; i < 5; i++) push(32'hC000 + i);
        idle(30);
        chk(tail - head == 5 && mem[3] == 16, "R6 stalled full ring", mem[3], 16);
        rmode = 1;
        idle(60);
        chk(head == tail && mem[3] == 36, "R7 drained full ring", mem[3], 36);

        // R9 sync with pending data
        rmode = 0;
        for (int i = 0; i < 4; i++) push(32'hD000 + i);
        do_sync("R9 sync drain");

        // R8 freeze, then R2 reload with new bounds
        rmode = 1;
        idle(20);
        cfg_done = 0;
        idle(10);
        snap = rd_ring_cnt;
        setup_ring(64, 100, 80);
        for (int i = 0; i < 4; i++) push(32'hE000 + i);
        idle(30);
        chk(rd_ring_cnt == snap && tail - head == 4, "R8 frozen", rd_ring_cnt, snap);
        cfg_done = 1;
        idle(60);
        chk(head == tail && mem[3] == 96, "R2 reload bounds", mem[3], 96);
        push(32'hF000); push(32'hF001);
        idle(30);
        chk(mem[3] == 68, "R4 wrap new bounds", mem[3], 68);

        // Random traffic with occasional sync
        rmode = 0;
        for (int i = 0; i < 300; i++) begin
            push($urandom);
            if ($urandom % 8 == 0) idle($urandom % 6);
            if ($urandom % 50 == 0) do_sync("R9 random sync");
        end
        do_sync("R9 final sync");
        chk(mem[3] == mem[2], "R7 final pointers", mem[3], mem[2]);

        summary();
        $finish;
    end
endmodule